// File: doc/BRIEF.md
# Three-Tap Programmable Edge Filter

This block applies a horizontal three-tap FIR to one 8-bit pixel channel. Each pixel is weighted together with its left and right neighbours on the same line. With suitable weights the block sharpens or blurs, and any other weight set gives a general-purpose kernel. Three coefficient registers are written through a small write port. Each coefficient is a signed byte with one sign bit and seven fraction bits. An enable input selects either the filtered result or the untouched pixel.

The input is a stream of beats. Each beat carries a valid strobe, line-start and line-end markers, and the pixel value. A pixel can only be filtered once its right-hand neighbour is known. For that reason, the result for a pixel leaves the block one clock after the *following* valid beat has been accepted. The markers of that pixel come out with it. At the two ends of a line, the missing neighbour is replaced by the end pixel itself. A colour image needs one instance per channel.

Top module: `pix_edge_fir`

## Requirements
- R1: After reset, `out_vld`, `out_sol`, `out_eol` and `out_pix` are 0. The coefficients reset to next = 00h, current = 7Fh and previous = 00h.
- R2: A write with `cfg_we` = 1 loads `cfg_wdata` into one coefficient, chosen by `cfg_addr`: 0 selects the next-pixel weight (A), 1 the current-pixel weight (B) and 2 the previous-pixel weight (C). The new value applies to every result computed from the following clock on. A write to address 3 changes nothing.
- R3: A coefficient byte is read as a two's-complement number divided by 128. Bit 7 is the sign. 10h means 0.125, 40h means 0.5, C0h means −0.5 and 80h means −1.0.
- R4: With `filt_en` = 1, the result for pixel j is computed in three steps:
  - the sum s = A·p[j+1] + B·p[j] + C·p[j−1], formed at full precision;
  - 64 is added to s;
  - the total is divided by 128, rounding toward minus infinity.
- R5: A result above 255 is output as 255. A result below 0 is output as 0.
- R6: For a pixel marked as line start, the previous neighbour is replaced by the pixel itself.
- R7: For a pixel marked as line end, the next neighbour is replaced by the pixel itself. A pixel marked as both start and end uses itself for both neighbours.
- R8: With `filt_en` = 0, the result for pixel j equals p[j] unchanged. `filt_en` is sampled in the clock when pixel j+1 is accepted.
- R9: The result for pixel j is presented in the clock after pixel j+1 is accepted, with `out_vld` = 1. In every other clock `out_vld` = 0 and `out_pix` holds its last value. The first beat after reset produces no result.
- R10: `out_sol` and `out_eol` repeat the line-start and line-end markers of pixel j alongside its result. Both are 0 whenever `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 2 | Coefficient select (0 next, 1 current, 2 previous) |
| cfg_wdata | input | 8 | Coefficient value, sign plus seven fraction bits |
| filt_en | input | 1 | 1 = filtered output, 0 = bypass |
| in_vld | input | 1 | Input beat valid |
| in_sol | input | 1 | Input pixel is the first of its line |
| in_eol | input | 1 | Input pixel is the last of its line |
| in_pix | input | 8 | Input pixel value |
| out_vld | output | 1 | Result valid |
| out_sol | output | 1 | Result belongs to a line-start pixel |
| out_eol | output | 1 | Result belongs to a line-end pixel |
| out_pix | output | 8 | Filtered or bypassed pixel |

## Verification
The assertions check several rules on every clock:
- a result appears only after an accepted beat, and the output value holds in idle clocks;
- the markers stay in step with the centre pixel and are never raised without a result;
- bypass returns the centre pixel unchanged;
- coefficient writes land in the selected register, and the spare address leaves all three untouched.

The arithmetic is shown only by the bench's scenarios, which compare each result with an independently computed expectation. These scenarios cover the rounding and clamping at both ends, the coefficient encoding, edge replication on short and single-pixel lines, and bypass toggling in the middle of a line.

// File: rtl/pix_edge_pkg.sv
package pix_edge_pkg;
  localparam int PIX_W   = 8;
  localparam int CF_W    = 8;
  localparam int CF_FRAC = CF_W - 1;
  localparam int NTAP    = 3;
  localparam int ADDR_W  = $clog2(NTAP + 1);
  localparam int ACC_W   = PIX_W + CF_W + 2;

  // tap slots: fixed order that the coefficient address map decodes
  localparam int TAP_NXT = 0;
  localparam int TAP_CUR = 1;
  localparam int TAP_PRV = 2;

  localparam logic [CF_W-1:0]         CF_NEAR_ONE = {1'b0, {(CF_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] RND_K       = ACC_W'(1) <<< (CF_FRAC - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX_S   = ACC_W'((1 << PIX_W) - 1);

  typedef logic [NTAP-1:0][PIX_W-1:0] tap_vec_t;
  typedef logic [NTAP-1:0][CF_W-1:0]  coef_vec_t;

  function automatic logic [CF_W-1:0] pef_coef_rst(input int k);
    return (k == TAP_CUR) ? CF_NEAR_ONE : '0;
  endfunction

  // unsigned pixel times signed fixed-point weight, full precision
  function automatic logic signed [ACC_W-1:0] pef_tap_prod(
      input logic [PIX_W-1:0] px, input logic [CF_W-1:0] cf);
    logic signed [ACC_W-1:0] a, b;
    a = $signed({{(ACC_W-PIX_W){1'b0}}, px});
    b = $signed({{(ACC_W-CF_W){cf[CF_W-1]}}, cf});
    return a * b;
  endfunction

  // add half an LSB, drop the fraction, saturate to the pixel range
  function automatic logic [PIX_W-1:0] pef_round_clamp(
      input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] r;
    r = (acc + RND_K) >>> CF_FRAC;
    if (r < 0)              return '0;
    else if (r > PIX_MAX_S) return '1;
    else                    return r[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/pef_coef_bank.sv
module pef_coef_bank
  import pix_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CF_W-1:0]   cfg_wdata,
  output coef_vec_t         coef
);
  for (genvar k = 0; k < NTAP; k++) begin : g_coef
    logic hit;
    assign hit = cfg_we && (cfg_addr == ADDR_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)   coef[k] <= pef_coef_rst(k);
      else if (hit) coef[k] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/pef_window.sv
module pef_window
  import pix_edge_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_sol,
  input  logic             in_eol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             fire,
  output tap_vec_t         taps,
  output logic             cur_sol,
  output logic             cur_eol
);
  logic             primed;
  logic [PIX_W-1:0] s_cur, s_prv;

  // a centre pixel is ready once its right neighbour arrives
  assign fire = in_vld && primed;

  always_comb begin
    taps[TAP_CUR] = s_cur;
    taps[TAP_NXT] = cur_eol ? s_cur : in_pix;
    taps[TAP_PRV] = cur_sol ? s_cur : s_prv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      s_cur   <= '0;
      s_prv   <= '0;
      cur_sol <= 1'b0;
      cur_eol <= 1'b0;
    end else if (in_vld) begin
      primed  <= 1'b1;
      s_prv   <= s_cur;
      s_cur   <= in_pix;
      cur_sol <= in_sol;
      cur_eol <= in_eol;
    end
  end
endmodule

// File: rtl/pef_mac.sv
module pef_mac
  import pix_edge_pkg::*;
(
  input  tap_vec_t         taps,
  input  coef_vec_t        coef,
  output logic [PIX_W-1:0] y
);
  logic signed [ACC_W-1:0] prod [NTAP];
  logic signed [ACC_W-1:0] acc;

  for (genvar k = 0; k < NTAP; k++) begin : g_prod
    assign prod[k] = pef_tap_prod(taps[k], coef[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + prod[k];
  end

  assign y = pef_round_clamp(acc);
endmodule

// File: rtl/pix_edge_fir.sv
module pix_edge_fir
  import pix_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CF_W-1:0]   cfg_wdata,
  input  logic              filt_en,
  input  logic              in_vld,
  input  logic              in_sol,
  input  logic              in_eol,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_vld,
  output logic              out_sol,
  output logic              out_eol,
  output logic [PIX_W-1:0]  out_pix
);
  coef_vec_t        coef;
  tap_vec_t         taps;
  logic             win_fire;
  logic             cur_sol, cur_eol;
  logic [PIX_W-1:0] filt_y;
  logic [PIX_W-1:0] tap_cur;

  assign tap_cur = taps[TAP_CUR];

  pef_coef_bank u_coef (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .coef
  );

  pef_window u_win (
    .clk, .rst_n, .in_vld, .in_sol, .in_eol, .in_pix,
    .fire(win_fire), .taps, .cur_sol, .cur_eol
  );

  pef_mac u_mac (.taps, .coef, .y(filt_y));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_sol <= 1'b0;
      out_eol <= 1'b0;
      out_pix <= '0;
    end else if (win_fire) begin
      out_vld <= 1'b1;
      out_sol <= cur_sol;
      out_eol <= cur_eol;
      out_pix <= filt_en ? filt_y : tap_cur;
    end else begin
      out_vld <= 1'b0;
      out_sol <= 1'b0;
      out_eol <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_edge_fir_chk.sv
module pix_edge_fir_chk
  import pix_edge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [CF_W-1:0]   cfg_wdata,
  input logic              filt_en,
  input logic              in_vld,
  input logic              out_vld,
  input logic              out_sol,
  input logic              out_eol,
  input logic [PIX_W-1:0]  out_pix,
  input logic [PIX_W-1:0]  tap_cur,
  input logic              cur_sol,
  input logic              cur_eol,
  input coef_vec_t         coef
);
  p_vld_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_pix));

  p_bypass_centre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !$past(filt_en)) |-> (out_pix == $past(tap_cur)));

  p_marker_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_sol == $past(cur_sol) && out_eol == $past(cur_eol)));

  p_marker_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_eol) |-> out_vld);

  p_coef_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && cfg_addr == ADDR_W'(TAP_CUR)) |-> (coef[TAP_CUR] == $past(cfg_wdata)));

  p_spare_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we && cfg_addr == ADDR_W'(NTAP)) |-> $stable(coef));
endmodule

bind pix_edge_fir pix_edge_fir_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .filt_en(filt_en), .in_vld(in_vld),
  .out_vld(out_vld), .out_sol(out_sol), .out_eol(out_eol), .out_pix(out_pix),
  .tap_cur(tap_cur), .cur_sol(cur_sol), .cur_eol(cur_eol), .coef(coef)
);

// File: tb/pix_edge_fir_tb_top.sv
`timescale 1ns/100ps
module pix_edge_fir_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       filt_en = 1'b1;
  logic       in_vld = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [7:0] in_pix = '0;
  logic       out_vld, out_sol, out_eol;
  logic [7:0] out_pix;

  always #2.5 clk = ~clk;

  pix_edge_fir dut_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .filt_en,
    .in_vld, .in_sol, .in_eol, .in_pix,
    .out_vld, .out_sol, .out_eol, .out_pix
  );

  int    errs = 0, checks = 0;
  bit    done = 0;
  int    mc [3] = '{0, 127, 0};   // model weights in 1/128 units: next, current, previous
  bit    have = 0;
  int    c_pix = 0, p_pix = 0;
  bit    c_sol = 0, c_eol = 0;
  int    last_out = 0;
  string ovr = "";

  function automatic int sval(input logic [7:0] b);
    return b[7] ? int'(b) - 256 : int'(b);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic beat(input int x, input bit sol, input bit eol, input bit en);
    int    nx, pv, v, raw, exp;
    string tag;
    in_vld = 1; in_pix = 8'(x); in_sol = sol; in_eol = eol; filt_en = en; cfg_we = 0;
    exp = 0; tag = "R4";
    if (have) begin
      nx  = c_eol ? c_pix : x;
      pv  = c_sol ? c_pix : p_pix;
      v   = mc[0] * nx + mc[1] * c_pix + mc[2] * pv + 64;
      raw = (v < 0) ? -1 : v / 128;
      if (!en) begin exp = c_pix; tag = "R8"; end
      else begin
        exp = (raw < 0) ? 0 : (raw > 255 ? 255 : raw);
        if (raw < 0 || raw > 255) tag = "R5";
        else if (c_sol) tag = "R6";
        else if (c_eol) tag = "R7";
        if (ovr != "") tag = ovr;
      end
    end
    @(negedge clk);
    if (have) begin
      chk(out_vld == 1'b1, "R9", int'(out_vld), 1);
      chk(int'(out_pix) == exp, tag, int'(out_pix), exp);
      chk(out_sol == c_sol && out_eol == c_eol, "R10",
          int'({out_sol, out_eol}), int'({c_sol, c_eol}));
    end else begin
      chk(out_vld == 1'b0, "R9", int'(out_vld), 0);
    end
    p_pix = c_pix; c_pix = x; c_sol = sol; c_eol = eol; have = 1;
    last_out = int'(out_pix);
  endtask

  task automatic idle();
    in_vld = 0; in_pix = 8'($urandom); in_sol = 1'($urandom); in_eol = 1'($urandom);
    @(negedge clk);
    chk(out_vld == 1'b0, "R9", int'(out_vld), 0);
    chk(int'(out_pix) == last_out, "R9", int'(out_pix), last_out);
  endtask

  task automatic wr(input int a, input int d);
    in_vld = 0; cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 0;
    if (a < 3) mc[a] = sval(8'(d));
    chk(out_vld == 1'b0, "R2", int'(out_vld), 0);
  endtask

  function automatic int rpix();
    int r;
    r = int'($urandom % 4);
    if (r == 0) return 0;
    if (r == 1) return 255;
    return int'($urandom % 256);
  endfunction

  task automatic rline(input int n, input int en_mode);
    for (int i = 0; i < n; i++) begin
      bit en;
      en = (en_mode == 2) ? 1'($urandom) : 1'(en_mode);
      beat(rpix(), i == 0, i == n - 1, en);
      if ($urandom % 5 == 0) idle();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5871));
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    chk(out_vld == 0 && out_sol == 0 && out_eol == 0, "R1", int'({out_vld, out_sol, out_eol}), 0);
    chk(out_pix == 0, "R1", int'(out_pix), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: default weights 00h/7Fh/00h, so 255 comes out as 253
    ovr = "R1";
    beat(255, 1, 0, 1); beat(10, 0, 0, 1); beat(128, 0, 1, 1);
    ovr = "";
    // R3: fixed encodings 10h, 40h, C0h and 80h
    wr(0, 'h10); wr(1, 'h40); wr(2, 'hC0);
    ovr = "R3";
    beat(200, 1, 0, 1); beat(40, 0, 0, 1); beat(200, 0, 0, 1); beat(40, 0, 1, 1);
    wr(2, 'h80);
    beat(100, 1, 0, 1); beat(90, 0, 0, 1); beat(30, 0, 1, 1);
    ovr = "";
    // blur 0.25/0.5/0.25
    wr(0, 'h20); wr(1, 'h40); wr(2, 'h20);
    for (int l = 0; l < 20; l++) rline(2 + int'($urandom % 12), 1);
    // R2: spare address must leave the blur weights alone
    wr(3, 'hFF);
    ovr = "R2";
    beat(255, 1, 0, 1); beat(0, 0, 0, 1); beat(255, 0, 1, 1);
    ovr = "";
    // sharpen -0.25/max/-0.25, saturation in both directions (R5)
    wr(0, 'hE0); wr(1, 'h7F); wr(2, 'hE0);
    for (int l = 0; l < 20; l++) rline(2 + int'($urandom % 12), 1);
    wr(1, 'h7F); wr(0, 'h7F); wr(2, 'h7F);
    beat(255, 1, 0, 1); beat(255, 0, 0, 1); beat(255, 0, 1, 1);
    wr(0, 'h80); wr(1, 'h00); wr(2, 'h80);
    beat(255, 1, 0, 1); beat(255, 0, 0, 1); beat(255, 0, 1, 1);
    // single-pixel lines (R6 and R7 together)
    wr(0, 'h40); wr(1, 'h20); wr(2, 'h10);
    for (int i = 0; i < 10; i++) beat(rpix(), 1, 1, 1);
    // bypass lines and mid-line toggling (R8)
    for (int l = 0; l < 10; l++) rline(1 + int'($urandom % 10), 0);
    for (int l = 0; l < 20; l++) rline(1 + int'($urandom % 10), 2);
    // random weights, lengths, gaps
    for (int l = 0; l < 150; l++) begin
      if ($urandom % 3 == 0) wr(int'($urandom % 4), int'($urandom % 256));
      rline(1 + int'($urandom % 16), 2);
    end
    beat(0, 1, 0, 1);   // flushes the last real pixel
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule